// File: doc/BRIEF.md
# Converter Sample Buffer with Mode-Selected Status Byte

This block stores converter samples in a 2048-entry first-in first-out buffer. It keeps a count of the samples held and gives the host an 8-bit status byte. The producer side offers one sample per cycle on a write strobe. The host removes the oldest sample with a read strobe, and the data appears on a registered output one clock later.

The layout of the status byte depends on a mode input. In basic mode the byte carries the low eight bits of the sample count. In extended mode the upper nibble carries the top four count bits and the lower nibble carries four flags: overflow, full, half-full and empty. A write attempted while the buffer is full sets a sticky overflow flag. After that, every new sample is refused until the host pulses the buffer-clear input. Reads still drain the stored samples while the flag is set.

Top module: `adc_sample_buffer`

## Requirements
- R1: With `stat_mode` = 0, `status[7:0]` equals the low eight bits of the sample count.
- R2: With `stat_mode` = 1, `status[7:4]` equals count bits 11..8, and bits 3, 2, 1, 0 carry overflow, full, half-full and empty, in that order.
- R3: A write strobe while the count is 2048 stores nothing and sets overflow.
- R4: Once overflow is set, it stays set and every write is refused until a clear. Reads still remove samples.
- R5: Full (status bit 2 in extended mode) is 1 exactly when the count is 2048.
- R6: Half-full (status bit 1 in extended mode) is 1 exactly when the count is 1024 or more.
- R7: Empty (status bit 0 in extended mode) is 1 exactly when the count is 0.
- R8: While `rst_n` is low, `status` reads 0x00 in both modes and `rd_data` is 0.
- R9: Reads return samples oldest first on `rd_data` one clock after the strobe. A read while empty leaves `rd_data` and the count unchanged.
- R10: A read and a write in the same cycle on a buffer that is neither full nor empty leave the count unchanged.
- R11: `clear` empties the buffer, resets both pointers and drops overflow in one clock. It overrides any read or write in that cycle.
- R12: A count change caused by a strobe is visible on `status` right after the clock edge that samples the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Synchronous buffer clear |
| wr_en | input | 1 | Sample write strobe |
| wr_data | input | 16 | Sample to store |
| rd_en | input | 1 | Host read strobe |
| rd_data | output | 16 | Oldest sample, registered |
| stat_mode | input | 1 | 0 = basic layout, 1 = extended layout |
| status | output | 8 | Status byte |

## Verification
The count, the flags and the pointers are registered, so a strobe driven before a rising edge appears on `status` as soon as that edge has passed. The status byte is combinational from that state and from `stat_mode`, so a change of mode shows up without a clock. Read data has one register stage and is due after the same edge as the count. The bench drives inputs on the falling edge, waits for one rising edge, and compares at the next falling edge, where both results have settled.

// File: rtl/adc_fifo_pkg.sv
package adc_fifo_pkg;
   localparam int STAT_W  = 8;
   localparam int HI_BITS = 4;

   typedef enum logic {
      STAT_BASIC = 1'b0,
      STAT_EXT   = 1'b1
   } stat_mode_e;

   // field order equals bit order 3..0 of the extended byte
   typedef struct packed {
      logic ovf;
      logic full;
      logic half;
      logic empty;
   } fifo_flags_t;
endpackage

// File: rtl/adc_fifo_level.sv
module adc_fifo_level #(
   parameter int DEPTH = 2048,
   localparam int CNT_W = $clog2(DEPTH) + 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clear,
   input  logic                       wr_en,
   input  logic                       rd_en,
   output logic                       wr_ok,
   output logic                       rd_ok,
   output logic [CNT_W-1:0]           count,
   output adc_fifo_pkg::fifo_flags_t  flags
);
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
   localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(DEPTH / 2);

   logic [CNT_W-1:0] cnt_q;
   logic             ovf_q;
   logic             is_full, is_empty;

   assign is_full  = (cnt_q == FULL_CNT);
   assign is_empty = (cnt_q == '0);
   assign wr_ok    = wr_en && !is_full && !ovf_q && !clear;
   assign rd_ok    = rd_en && !is_empty && !clear;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ovf_q <= 1'b0;
      end else if (clear) begin
         cnt_q <= '0;
         ovf_q <= 1'b0;
      end else begin
         if (wr_en && is_full) ovf_q <= 1'b1;
         case ({wr_ok, rd_ok})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign count       = cnt_q;
   assign flags.ovf   = ovf_q;
   assign flags.full  = is_full;
   assign flags.half  = (cnt_q >= HALF_CNT);
   assign flags.empty = is_empty;

   assert_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= FULL_CNT);
   assert_ovf_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && is_full && !clear) |=> ovf_q);
   assert_ovf_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q && !clear) |=> ovf_q);
   assert_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q && !clear && !rd_en) |=> $stable(cnt_q));
   assert_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (cnt_q == '0) && !ovf_q);
   assert_rdwr_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && rd_en && !is_full && !is_empty && !ovf_q && !clear)
      |=> $stable(cnt_q));
endmodule

// File: rtl/adc_fifo_store.sv
module adc_fifo_store #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 2048,
   localparam int PTR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              wr_ok,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_ok,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wp_q, rp_q;
   logic [DATA_W-1:0] rd_q;

   always_ff @(posedge clk) begin
      if (wr_ok) mem[wp_q] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q <= '0;
         rp_q <= '0;
         rd_q <= '0;
      end else if (clear) begin
         wp_q <= '0;
         rp_q <= '0;
      end else begin
         if (wr_ok) wp_q <= wp_q + 1'b1;
         if (rd_ok) begin
            rd_q <= mem[rp_q];
            rp_q <= rp_q + 1'b1;
         end
      end
   end

   assign rd_data = rd_q;

   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_ok |=> $stable(rd_q));
   assert_ptr_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (wp_q == '0) && (rp_q == '0));
endmodule

// File: rtl/adc_fifo_status.sv
module adc_fifo_status #(
   parameter int CNT_W = 12
) (
   input  logic                      rst_n,
   input  logic                      mode,
   input  logic [CNT_W-1:0]          count,
   input  adc_fifo_pkg::fifo_flags_t flags,
   output logic [7:0]                status
);
   import adc_fifo_pkg::*;

   logic [STAT_W-1:0] basic_b, ext_b;

   generate
      if (CNT_W < STAT_W) begin : g_bad
         $error("adc_fifo_status: count narrower than status byte");
      end
      if (CNT_W - HI_BITS >= STAT_W) begin : g_wide
         assign basic_b = count[STAT_W-1:0];
      end else begin : g_narrow
         assign basic_b = count[STAT_W-1:0];
      end
   endgenerate

   assign ext_b  = {count[CNT_W-1 -: HI_BITS], flags};
   assign status = !rst_n ? '0 :
                   (stat_mode_e'(mode) == STAT_EXT) ? ext_b : basic_b;
endmodule

// File: rtl/adc_sample_buffer.sv
module adc_sample_buffer #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 2048
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   input  logic              stat_mode,
   output logic [7:0]        status
);
   localparam int CNT_W = $clog2(DEPTH) + 1;

   generate
      if ((1 << $clog2(DEPTH)) != DEPTH) begin : g_pow2
         $error("adc_sample_buffer: DEPTH must be a power of two");
      end
      if (DEPTH < 128) begin : g_min
         $error("adc_sample_buffer: DEPTH must be at least 128");
      end
      if (DATA_W < 1) begin : g_dw
         $error("adc_sample_buffer: DATA_W must be positive");
      end
   endgenerate

   logic                      wr_ok, rd_ok;
   logic [CNT_W-1:0]          count;
   adc_fifo_pkg::fifo_flags_t flags;

   adc_fifo_level #(.DEPTH(DEPTH)) u_level (
      .clk(clk), .rst_n(rst_n), .clear(clear),
      .wr_en(wr_en), .rd_en(rd_en),
      .wr_ok(wr_ok), .rd_ok(rd_ok),
      .count(count), .flags(flags)
   );

   adc_fifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk(clk), .rst_n(rst_n), .clear(clear),
      .wr_ok(wr_ok), .wr_data(wr_data),
      .rd_ok(rd_ok), .rd_data(rd_data)
   );

   adc_fifo_status #(.CNT_W(CNT_W)) u_status (
      .rst_n(rst_n), .mode(stat_mode),
      .count(count), .flags(flags), .status(status)
   );
endmodule

// File: tb/adc_sample_buffer_bench.sv
module adc_sample_buffer_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clear = 1'b0, wr_en = 1'b0, rd_en = 1'b0, stat_mode = 1'b0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;
   logic [7:0]  status;
   int          checks = 0, fails = 0;
   bit          done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   adc_sample_buffer u_adc_sample_buffer (
      .clk(clk), .rst_n(rst_n), .clear(clear), .wr_en(wr_en),
      .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
      .stat_mode(stat_mode), .status(status)
   );

   // {clear, wr, rd, mode, data[15:0], exp_status[7:0], exp_rd[15:0]}
   localparam logic [43:0] VEC [NV] = '{
      {4'b0100, 16'h1111, 8'h01, 16'h0000},  // R1 R12 one sample
      {4'b0101, 16'h2222, 8'h00, 16'h0000},  // R2 two samples, no flags
      {4'b0110, 16'h3333, 8'h02, 16'h1111},  // R10 read+write, count 2
      {4'b0010, 16'h0000, 8'h01, 16'h2222},  // R9 oldest first
      {4'b0011, 16'h0000, 8'h01, 16'h3333},  // R7 drained, empty flag
      {4'b0011, 16'h0000, 8'h01, 16'h3333},  // R9 read while empty
      {4'b0110, 16'h4444, 8'h01, 16'h3333},  // R10 empty: write only
      {4'b1101, 16'h5555, 8'h01, 16'h3333},  // R11 clear beats write
      {4'b0100, 16'h6666, 8'h01, 16'h3333},  // R11 fresh write
      {4'b0010, 16'h0000, 8'h00, 16'h6666}   // R11 pointers were reset
   };

   task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
      clear = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
   endtask

   task automatic push(logic [15:0] d);
      wr_en = 1'b1; wr_data = d;
      step();
   endtask

   task automatic pull();
      rd_en = 1'b1;
      step();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      stat_mode = 1'b1;
      repeat (3) @(negedge clk);
      chk("R8 ext status in reset", 16'(status), 16'h00);
      stat_mode = 1'b0;
      #1;
      chk("R8 basic status in reset", 16'(status), 16'h00);
      chk("R8 rd_data in reset", rd_data, 16'h0000);
      rst_n = 1'b1;
      @(negedge clk);
      stat_mode = 1'b1;
      #1;
      chk("R7 empty after reset", 16'(status), 16'h01);

      for (int i = 0; i < NV; i++) begin
         clear = VEC[i][43]; wr_en = VEC[i][42]; rd_en = VEC[i][41];
         stat_mode = VEC[i][40]; wr_data = VEC[i][39:24];
         step();
         chk(stat_mode ? "R2 status" : "R1 status", 16'(status), 16'(VEC[i][23:16]));
         chk("R9 rd_data", rd_data, VEC[i][15:0]);
      end
      // leaves one item read out; count now 0

      stat_mode = 1'b1;
      for (int i = 0; i < 1023; i++) push(16'(i));
      chk("R6 below half", 16'(status), 16'h30);
      push(16'd1023);
      chk("R6 half reached", 16'(status), 16'h42);
      stat_mode = 1'b0; #1;
      chk("R1 low byte at 1024", 16'(status), 16'h00);
      stat_mode = 1'b1;
      for (int i = 1024; i < 2047; i++) push(16'(i));
      chk("R5 not full at 2047", 16'(status), 16'h72);
      stat_mode = 1'b0; #1;
      chk("R1 low byte at 2047", 16'(status), 16'hFF);
      stat_mode = 1'b1;
      push(16'd2047);
      chk("R5 full at 2048", 16'(status), 16'h86);
      push(16'hBEEF);
      chk("R3 overflow on write at full", 16'(status), 16'h8E);
      pull();
      chk("R4 read drains during overflow", rd_data, 16'h0000);
      chk("R4 overflow sticky", 16'(status), 16'h7A);
      push(16'hCAFE);
      chk("R4 write refused", 16'(status), 16'h7A);
      pull();
      chk("R4 order kept", rd_data, 16'h0001);
      clear = 1'b1; rd_en = 1'b1;
      step();
      chk("R11 clear drops count and overflow", 16'(status), 16'h01);
      chk("R11 clear beats read", rd_data, 16'h0001);
      push(16'h1234);
      pull();
      chk("R11 write accepted after clear", rd_data, 16'h1234);
      chk("R12 count back to zero", 16'(status), 16'h01);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule